// File: doc/BRIEF.md
# Binary64 to Signed 64-bit Integer Truncating Converter

This unit takes the bit pattern of an IEEE-754 double-precision number and returns the signed 64-bit integer that remains once the fractional part is cut off. The result is always rounded toward zero. The unit accepts one operand per clock, qualified by `valid_i`. The integer and a six-bit exception status appear one cycle later, qualified by `valid_o`.

Finite values whose integer part does not fit in a signed 64-bit word do not saturate. They return the low 64 bits of the exact integer, negated in two's complement when the input is negative. Such values raise integer overflow together with inexact. Infinities and NaNs return zero and raise only invalid. The status vector follows a fixed control-register layout, so downstream logic can OR it into a wider status word at a fixed offset. Three of its fields exist only to keep that layout and are never set by this unit.

Top module: `f64_to_i64_trunc`

## Requirements
- R1: Finite inputs whose magnitude is at least 1 and whose integer part fits the signed range convert with truncation toward zero. Examples: 1.5 gives 1, -1.0 gives -1, -2.75 gives -2.
- R2: Inexact (status bit 4) is set exactly when nonzero fraction bits are discarded. Exact inputs such as 1.0 and 2^32 return with an all-zero status.
- R3: Nonzero finite inputs with magnitude below 1, subnormals included, return 0 with only inexact set. Zero of either sign returns 0 with no status bit set.
- R4: The input -2^63 returns 0x8000000000000000 with no status bit set.
- R5: Any other finite input whose integer part has magnitude of at least 2^63 behaves as follows:
  - The result is the low 64 bits of the exact integer part, negated in two's complement when the sign is set.
  - Both integer overflow (status bit 5) and inexact (status bit 4) are set.
  - Examples: 2^63 gives 0x8000000000000000, 2^64 gives 0, and 0x1.ccc×2^64 gives 0xccc0000000000000.
- R6: An input with an all-ones exponent (infinity or any NaN) returns 0 with only invalid (status bit 0) set.
- R7: `status_o` has six bits: bit 0 invalid, bit 1 divide-by-zero, bit 2 overflow, bit 3 underflow, bit 4 inexact, bit 5 integer overflow. Bits 1 to 3 are always 0.
- R8: `valid_o` is `valid_i` delayed by one clock, and the result and status of an operand appear in that same cycle. Reset clears `valid_o`, `result_o` and `status_o` to 0.
- R9: While `valid_i` is low, `result_o` and `status_o` keep their previous values whatever `operand_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand strobe |
| operand_i | input | 64 | Binary64 bit pattern |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| result_o | output | 64 | Truncated signed integer |
| status_o | output | 6 | Exception status (layout in R7) |

## Verification
Integer overflow and inexact are the two functions that must fire together. The bench provokes this by sweeping the exponent across the boundary at 2^63 and far past 2^64 with scattered fractions, so the wrapped low bits, the overflow decision and the inexact decision are all judged on the same result. The sharpest case sits right at that boundary: -2^63 must raise neither flag, while +2^63 and -2^63 with any fraction bit set must raise both. Every result and status pair is compared against a model that builds the exact integer in a wide vector.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int unsigned EXP_W = 11;
  localparam int unsigned MAN_W = 52;
  localparam int unsigned SIG_W = MAN_W + 1;
  localparam int unsigned FP_W  = EXP_W + MAN_W + 1;
  localparam int unsigned INT_W = 64;
  localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned ST_W  = 6;
  localparam int unsigned ST_INV = 0;
  localparam int unsigned ST_DZE = 1;
  localparam int unsigned ST_OVF = 2;
  localparam int unsigned ST_UNF = 3;
  localparam int unsigned ST_INE = 4;
  localparam int unsigned ST_IOV = 5;

  typedef enum logic [1:0] {
    CLS_TINY    = 2'd0,  // zero or subnormal
    CLS_FINITE  = 2'd1,
    CLS_SPECIAL = 2'd2   // inf or nan
  } op_class_e;

  typedef struct packed {
    logic             sign;
    op_class_e        cls;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } fp_fields_t;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  output fp_fields_t      fields_o
);
  logic [EXP_W-1:0] exp_raw;
  logic [MAN_W-1:0] man_raw;

  assign exp_raw = op_i[FP_W-2 -: EXP_W];
  assign man_raw = op_i[MAN_W-1:0];

  always_comb begin
    fields_o.sign = op_i[FP_W-1];
    fields_o.exp  = exp_raw;
    fields_o.sig  = {(exp_raw != '0), man_raw};
    if (&exp_raw)          fields_o.cls = CLS_SPECIAL;
    else if (exp_raw == '0) fields_o.cls = CLS_TINY;
    else                   fields_o.cls = CLS_FINITE;
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
(
  input  fp_fields_t       fields_i,
  output logic [INT_W-1:0] mag_o,      // low bits of |integer part|
  output logic             dropped_o,  // nonzero fraction discarded
  output logic             big_o,      // |integer part| >= 2^(INT_W-1)
  output logic             min_exact_o // |value| is exactly 2^(INT_W-1)
);
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_INT = EXP_W'(BIAS + MAN_W);
  localparam logic [EXP_W-1:0] EXP_BIG = EXP_W'(BIAS + INT_W - 1);

  logic [EXP_W-1:0] rsh, lsh;
  logic [SIG_W-1:0] sig_rs;
  logic [INT_W-1:0] sig_ls;

  assign rsh    = EXP_INT - fields_i.exp;
  assign lsh    = fields_i.exp - EXP_INT;
  assign sig_rs = fields_i.sig >> rsh;
  assign sig_ls = {{(INT_W-SIG_W){1'b0}}, fields_i.sig} << lsh;

  always_comb begin
    mag_o       = '0;
    dropped_o   = 1'b0;
    big_o       = 1'b0;
    min_exact_o = 1'b0;
    unique case (fields_i.cls)
      CLS_TINY:    dropped_o = |fields_i.sig;
      CLS_FINITE: begin
        if (fields_i.exp < EXP_ONE) begin
          dropped_o = 1'b1;
        end else if (fields_i.exp <= EXP_INT) begin
          mag_o     = {{(INT_W-SIG_W){1'b0}}, sig_rs};
          dropped_o = |(fields_i.sig & ~({SIG_W{1'b1}} << rsh));
        end else begin
          mag_o       = sig_ls;
          big_o       = fields_i.exp >= EXP_BIG;
          min_exact_o = (fields_i.exp == EXP_BIG) && (fields_i.sig[MAN_W-1:0] == '0);
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/f64_to_i64_trunc.sv
module f64_to_i64_trunc
  import f2i_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [FP_W-1:0]  operand_i,
  output logic             valid_o,
  output logic [INT_W-1:0] result_o,
  output logic [ST_W-1:0]  status_o
);
  fp_fields_t       fields;
  logic [INT_W-1:0] mag;
  logic             dropped, big, min_exact;
  logic             flag_inv, flag_iov, flag_ine;
  logic [INT_W-1:0] res_d;
  logic [ST_W-1:0]  st_d;

  f2i_classify u_classify (
    .op_i     (operand_i),
    .fields_o (fields)
  );

  f2i_align u_align (
    .fields_i    (fields),
    .mag_o       (mag),
    .dropped_o   (dropped),
    .big_o       (big),
    .min_exact_o (min_exact)
  );

  assign flag_inv = (fields.cls == CLS_SPECIAL);
  // only -2^63 is a legal value at or beyond the magnitude limit
  assign flag_iov = big && !(fields.sign && min_exact);
  assign flag_ine = dropped || flag_iov;

  always_comb begin
    res_d = fields.sign ? (~mag + INT_W'(1)) : mag;
    if (flag_inv) res_d = '0;
    for (int i = 0; i < ST_W; i++) begin
      unique case (i)
        ST_INV:  st_d[i] = flag_inv;
        ST_INE:  st_d[i] = flag_ine;
        ST_IOV:  st_d[i] = flag_iov;
        default: st_d[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      status_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        status_o <= st_d;
      end
    end
  end
endmodule

// File: rtl/f2i_checker.sv
module f2i_checker
  import f2i_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [FP_W-1:0]  operand_i,
  input logic             valid_o,
  input logic [INT_W-1:0] result_o,
  input logic [ST_W-1:0]  status_o
);
  localparam logic [EXP_W-1:0] EXP_BIG = EXP_W'(BIAS + INT_W - 1);

  assert_special_invalid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (&operand_i[FP_W-2 -: EXP_W]) |=> (result_o == '0) && (status_o == ST_W'(1 << ST_INV)));

  assert_zero_clean_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (operand_i[FP_W-2:0] == '0) |=> (result_o == '0) && (status_o == '0));

  assert_layout_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (status_o[ST_UNF:ST_DZE] == '0));

  assert_iov_with_ine_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && status_o[ST_IOV] |-> status_o[ST_INE]);

  assert_valid_on_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_valid_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(status_o));

  assert_neg_sign_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && operand_i[FP_W-1] && (operand_i[FP_W-2 -: EXP_W] < EXP_BIG)
    |=> result_o[INT_W-1] || (result_o == '0));
endmodule

bind f64_to_i64_trunc f2i_checker u_f2i_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .operand_i (operand_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .status_o  (status_o)
);

// File: tb/f64_to_i64_trunc_bench.sv
module f64_to_i64_trunc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [5:0]  status_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] op;
    logic [63:0] res;
    logic [5:0]  st;
    int          due;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  f64_to_i64_trunc u_f64_to_i64_trunc (
    .clk_i (clk), .rst_ni (rst_n), .valid_i (valid_i), .operand_i (operand_i),
    .valid_o (valid_o), .result_o (result_o), .status_o (status_o)
  );

  // exact integer built in a wide vector: value = sig * 2^(e_eff - 1075)
  task automatic model(input logic [63:0] op, output logic [63:0] r,
                       output logic [5:0] st, output string tag);
    logic [10:0]   e;
    logic [52:0]   sig;
    logic [2099:0] full, ip;
    logic          hi, fr, big, minx, iov, ine;
    e = op[62:52];
    if (&e) begin
      r = '0; st = 6'b000001; tag = "R6/R7";
      return;
    end
    sig  = {(e != 0), op[51:0]};
    full = 2100'(sig) << ((e == 0) ? 11'd1 : e);
    ip   = full >> 1075;
    fr   = |full[1074:0];
    hi   = |ip[2099:64];
    big  = hi | ip[63];
    minx = op[63] && !hi && (ip[63:0] == 64'h8000_0000_0000_0000) && !fr;
    iov  = big && !minx;
    ine  = fr || iov;
    r    = op[63] ? (64'd0 - ip[63:0]) : ip[63:0];
    st   = {iov, ine, 4'b0000};
    if (iov)            tag = "R5/R7";
    else if (minx)      tag = "R4/R7";
    else if (e < 1023)  tag = "R3/R7";
    else if (fr)        tag = "R1/R2";
    else                tag = "R1/R2/R7";
  endtask

  task automatic apply(input logic [63:0] op);
    item_t it;
    model(op, it.res, it.st, it.tag);
    it.op  = op;
    it.due = cyc + 1;
    q.push_back(it);
    operand_i = op;
    valid_i   = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      item_t it;
      n_chk++;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected valid_o actual=1 expected=0");
      end else begin
        it = q.pop_front();
        if (it.due != cyc) begin
          n_fail++;
          $display("FAIL R8 op=%h latency actual cycle %0d expected %0d", it.op, cyc, it.due);
        end else if (result_o !== it.res || status_o !== it.st) begin
          n_fail++;
          $display("FAIL %s op=%h actual=(%h:%b) expected=(%h:%b)",
                   it.tag, it.op, result_o, status_o, it.res, it.st);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] keep_r;
    logic [5:0]  keep_s;
    repeat (3) @(negedge clk);
    n_chk++;  // R8 reset state
    if (valid_o !== 1'b0 || result_o !== '0 || status_o !== '0) begin
      n_fail++;
      $display("FAIL R8 reset actual=(%b %h %b) expected=(0 0 0)", valid_o, result_o, status_o);
    end
    rst_n = 1'b1;
    @(negedge clk);

    apply(64'h3FF0_0000_0000_0000);  // 1.0       R2 exact
    apply(64'hBFF0_0000_0000_0000);  // -1.0      R1
    apply(64'h3FF8_0000_0000_0000);  // 1.5       R1 R2
    apply(64'hC006_0000_0000_0000);  // -2.75     R1
    apply(64'h41F0_0000_0000_0000);  // 2^32      R2 exact
    apply(64'hC3E0_0000_0000_0000);  // -2^63     R4
    apply(64'h43E0_0000_0000_0000);  // 2^63      R5
    apply(64'h43F0_0000_0000_0000);  // 2^64      R5
    apply(64'h43FC_CC00_0000_0000);  // 0x1.ccc p64 R5
    apply(64'hC3E0_0000_0000_0001);  // just below -2^63 R5
    apply(64'h7FF0_0000_0000_0000);  // +inf      R6
    apply(64'hFFF0_0000_0000_0000);  // -inf      R6
    apply(64'h7FF8_0000_0000_0000);  // qnan      R6
    apply(64'h7FF0_0000_0000_0001);  // snan      R6
    apply(64'h0000_0000_0000_0000);  // +0        R3
    apply(64'h8000_0000_0000_0000);  // -0        R3
    apply(64'h0000_0000_0000_0001);  // min subnormal R3
    apply(64'h800F_FFFF_FFFF_FFFF);  // neg subnormal R3
    apply(64'h3FEF_FFFF_FFFF_FFFF);  // just below 1 R3
    apply(64'h4330_0000_0000_0001);  // 2^52+1 exact R2
    apply(64'h432F_FFFF_FFFF_FFFF);  // 2^52-0.5    R2
    apply(64'h7FEF_FFFF_FFFF_FFFF);  // max finite  R5
    idle(3);

    // exponent sweep around and across the integer boundaries, both signs
    for (int e = 1022; e <= 2047; e++) begin
      for (int k = 0; k < 6; k++) begin
        logic [63:0] rnd;
        rnd = {$urandom(), $urandom()};
        apply({rnd[63], 11'(e), (k == 0) ? 52'd0 : rnd[51:0]});
      end
    end
    for (int k = 0; k < 200; k++) begin
      logic [63:0] rnd;
      rnd = {$urandom(), $urandom()};
      apply({rnd[63], 11'($urandom_range(0, 1021)), rnd[51:0]});
    end
    idle(3);

    // R9: outputs hold while valid_i is low
    keep_r = result_o;
    keep_s = status_o;
    operand_i = 64'h7FF8_0000_0000_0000;
    repeat (4) @(negedge clk);
    n_chk++;
    if (result_o !== keep_r || status_o !== keep_s || valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 hold actual=(%h:%b:%b) expected=(%h:%b:0)",
               result_o, status_o, valid_o, keep_r, keep_s);
    end
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R8 pending results actual=%0d expected=0", q.size());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule